// File: doc/BRIEF.md
# Octal DTR Mode-Switch Sequencer

This block sits inside a serial NOR flash controller. On request it moves the attached flash device from single-line SPI (1-1-1) to octal double-transfer-rate operation (8D-8D-8D), or back again. For each direction it issues a short series of command frames to a lower-level command engine over a valid/ready request channel. It then reads the device ID and compares it with a stored copy to confirm that the device has actually changed mode.

A requester pulses `start` and selects the direction with `enable_sel`. The block then keeps `busy` high and pulses `done` for one clock, together with either `ok` or `err`. A mode register (`octal_mode`) records which protocol the device is in. It changes only when a switch succeeds. The ID length, the ID bytes, the address width for octal reads and the octal read wait-state count are static configuration inputs.

Top module: `odtr_switch_seq`

## Requirements
- R1: After reset `busy`, `done`, `ok`, `err` and `req_valid` are 0 and `octal_mode` is 0 (0 = 1-1-1, 1 = 8D-8D-8D).
- R2: An enable first sends a register write: opcode 0x72, address 0x00000300, 4 address bytes, 0 dummy cycles, write, length 1. Its data byte in `req_wdata[7:0]` is (20 − N) >> 1, where N is `wait_states`, and `req_wdata[15:8]` is 0. `req_proto` is the current `octal_mode` value (0 = 1-1-1, 1 = 8D-8D-8D).
- R3: An enable next sends a register write: opcode 0x72, address 0, 4 address bytes, 0 dummy cycles, length 1, data 0x02. It is also sent in the current `octal_mode` protocol.
- R4: An enable ends with a read-ID frame: opcode 0x9F, `req_proto` 1, address 0, `cfg_addr_bytes` address bytes, 4 dummy cycles, read, length 2×`id_len`. Response byte k is `rsp_data[8k+7:8k]`. The switch passes only if response bytes 2i and 2i+1 are both equal to ID byte i (`id_bytes[8i+7:8i]`) for every i below `id_len`.
- R5: A disable first sends a register write: opcode 0x72, `req_proto` 1, address 0, 4 address bytes, 0 dummy cycles, length 2, `req_wdata` 0x0000.
- R6: A disable ends with a read-ID frame: opcode 0x9F, `req_proto` 0, 0 address bytes, 0 dummy cycles, read, length `id_len`. The switch passes only if response byte i equals ID byte i for every i below `id_len`.
- R7: The block finishes with `err` and issues no request when any of these holds at start:
  - `id_len` is outside 3..6;
  - for an enable, N is above 20;
  - for an enable, N is odd.
- R8: A response with `rsp_err` set ends the sequence at once with `err`. No further request is issued.
- R9: `busy` is high from the clock after an accepted `start` until the clock after `done`. A `start` while busy is ignored. `done` lasts one clock, with exactly one of `ok`/`err`.
- R10: On `ok`, `octal_mode` takes the requested direction (1 for enable, 0 for disable). On `err` it keeps its previous value.
- R11: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and every request field holds its value. A response is accepted only after the request handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse |
| enable_sel | input | 1 | 1 = switch to octal DTR, 0 = switch to 1-1-1 |
| wait_states | input | 5 | Octal DTR read wait-state count N |
| cfg_addr_bytes | input | 3 | Address bytes for the octal read-ID |
| id_len | input | 3 | Expected ID length in bytes |
| id_bytes | input | 48 | Expected ID, byte i at [8i+7:8i] |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock completion pulse |
| ok | output | 1 | Switch confirmed (with done) |
| err | output | 1 | Switch failed (with done) |
| octal_mode | output | 1 | Current device protocol |
| req_valid | output | 1 | Command frame valid |
| req_ready | input | 1 | Engine accepts frame |
| req_opcode | output | 8 | Frame opcode |
| req_proto | output | 1 | 0 = 1-1-1, 1 = 8D-8D-8D |
| req_addr | output | 32 | Frame address |
| req_addr_bytes | output | 3 | Number of address bytes |
| req_dummy | output | 5 | Dummy cycles |
| req_is_read | output | 1 | 1 = read frame |
| req_len | output | 4 | Data bytes |
| req_wdata | output | 16 | Write data, first byte in [7:0] |
| rsp_valid | input | 1 | Engine response for the accepted frame |
| rsp_err | input | 1 | Engine reports failure |
| rsp_data | input | 96 | Read data, byte k at [8k+7:8k] |

## Verification
The bench builds the block with its default parameters:
- an ID of up to six bytes;
- a dummy-cycle base of 20;
- a 5-bit wait-state input.

These settings make both ends of the ID length range reachable: three-byte and six-byte IDs, with a 12-byte octal response. They also reach the extreme wait-state codes 0 and 10, and the out-of-range values 21 and odd counts. Because `octal_mode` carries over from one sequence to the next, the bench can issue an enable from an already octal device. That shows the register writes following the current protocol, and it lets errors be injected after the mode has flipped.

// File: rtl/odtr_pkg.sv
// Package: shared state encoding and command constants for the octal DTR
// mode-switch sequencer. Assumes a one-byte opcode and a 32-bit address field.
package odtr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_DC,
        ST_WR_ON,
        ST_RD_OCT,
        ST_WR_OFF,
        ST_RD_SPI,
        ST_FIN
    } seq_state_e;

    localparam logic [7:0]  OP_CFG_WRITE = 8'h72;
    localparam logic [7:0]  OP_READ_ID   = 8'h9F;
    localparam logic [31:0] ADDR_DUMMY   = 32'h0000_0300;
    localparam logic [31:0] ADDR_MODE    = 32'h0000_0000;
    localparam logic [7:0]  MODE_OCT_DTR = 8'h02;
    localparam logic [7:0]  MODE_SINGLE  = 8'h00;
    localparam logic        PROTO_SINGLE = 1'b0;
    localparam logic        PROTO_OCTAL  = 1'b1;
    localparam logic [2:0]  WR_ADDR_B    = 3'd4;
    localparam logic [4:0]  OCT_ID_DUMMY = 5'd4;

endpackage

// File: rtl/odtr_frame_builder.sv
// Module: maps the current sequencer state to the fields of one command frame.
// Purely combinational; assumes the dummy-cycle code was checked and latched
// by the caller and that the ID length is already range-checked.
module odtr_frame_builder
    import odtr_pkg::*;
#(
    parameter int WAIT_W   = 5,
    parameter int ID_LEN_W = 3,
    parameter int LEN_W    = 4
) (
    input  seq_state_e          state,
    input  logic                cur_proto,
    input  logic [WAIT_W-1:0]   dc_code,
    input  logic [2:0]          cfg_addr_bytes,
    input  logic [ID_LEN_W-1:0] id_len,
    output logic [7:0]          opcode,
    output logic                proto,
    output logic [31:0]         addr,
    output logic [2:0]          addr_bytes,
    output logic [4:0]          dummy,
    output logic                is_read,
    output logic [LEN_W-1:0]    len,
    output logic [15:0]         wdata
);

    // Select frame fields for each command step.
    always_comb begin
        opcode     = OP_CFG_WRITE;
        proto      = cur_proto;
        addr       = ADDR_MODE;
        addr_bytes = WR_ADDR_B;
        dummy      = '0;
        is_read    = 1'b0;
        len        = LEN_W'(1);
        wdata      = '0;
        case (state)
            ST_WR_DC: begin
                addr  = ADDR_DUMMY;
                wdata = {8'h00, 8'(dc_code)};
            end
            ST_WR_ON: begin
                wdata = {8'h00, MODE_OCT_DTR};
            end
            ST_RD_OCT: begin
                opcode     = OP_READ_ID;
                proto      = PROTO_OCTAL;
                addr_bytes = cfg_addr_bytes;
                dummy      = OCT_ID_DUMMY;
                is_read    = 1'b1;
                len        = LEN_W'({id_len, 1'b0});
            end
            ST_WR_OFF: begin
                proto = PROTO_OCTAL;
                len   = LEN_W'(2);
                wdata = {MODE_SINGLE, MODE_SINGLE};
            end
            ST_RD_SPI: begin
                opcode     = OP_READ_ID;
                proto      = PROTO_SINGLE;
                addr_bytes = '0;
                is_read    = 1'b1;
                len        = LEN_W'(id_len);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/odtr_id_check.sv
// Module: compares a read-ID response with the stored ID. In octal mode each
// ID byte must appear twice in a row; in single mode once. Bytes at or above
// the ID length are ignored. Assumes the response is packed byte 0 lowest.
module odtr_id_check #(
    parameter int ID_MAX   = 6,
    parameter int ID_LEN_W = 3
) (
    input  logic                  octal,
    input  logic [16*ID_MAX-1:0]  rx_data,
    input  logic [8*ID_MAX-1:0]   id_bytes,
    input  logic [ID_LEN_W-1:0]   id_len,
    output logic                  match
);

    logic [ID_MAX-1:0] byte_ok;

    for (genvar i = 0; i < ID_MAX; i++) begin : g_byte
        logic [7:0] exp_b;
        logic [7:0] first_b;
        logic [7:0] second_b;
        logic [7:0] single_b;
        assign exp_b    = id_bytes[8*i +: 8];
        assign first_b  = rx_data[16*i +: 8];
        assign second_b = rx_data[16*i+8 +: 8];
        assign single_b = rx_data[8*i +: 8];
        // Per-byte verdict: skipped beyond length, paired or single compare.
        always_comb begin
            if (ID_LEN_W'(i) >= id_len)
                byte_ok[i] = 1'b1;
            else if (octal)
                byte_ok[i] = (first_b == exp_b) && (second_b == exp_b);
            else
                byte_ok[i] = (single_b == exp_b);
        end
    end

    assign match = &byte_ok;

endmodule

// File: rtl/odtr_switch_seq.sv
// Module: top of the octal DTR mode-switch sequencer. Validates the
// configuration at start, steps through the write/read-ID frames for the
// chosen direction, confirms the ID and updates the mode register. Assumes one
// outstanding frame at a time and a single response per accepted frame.
module odtr_switch_seq
    import odtr_pkg::*;
#(
    parameter int ID_MAX  = 6,
    parameter int ID_MIN  = 3,
    parameter int DC_BASE = 20,
    parameter int WAIT_W  = 5,
    localparam int ID_LEN_W = $clog2(ID_MAX + 1),
    localparam int LEN_W    = $clog2(2 * ID_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 enable_sel,
    input  logic [WAIT_W-1:0]    wait_states,
    input  logic [2:0]           cfg_addr_bytes,
    input  logic [ID_LEN_W-1:0]  id_len,
    input  logic [8*ID_MAX-1:0]  id_bytes,
    output logic                 busy,
    output logic                 done,
    output logic                 ok,
    output logic                 err,
    output logic                 octal_mode,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [7:0]           req_opcode,
    output logic                 req_proto,
    output logic [31:0]          req_addr,
    output logic [2:0]           req_addr_bytes,
    output logic [4:0]           req_dummy,
    output logic                 req_is_read,
    output logic [LEN_W-1:0]     req_len,
    output logic [15:0]          req_wdata,
    input  logic                 rsp_valid,
    input  logic                 rsp_err,
    input  logic [16*ID_MAX-1:0] rsp_data
);

    seq_state_e        state_q;
    logic              wait_q;
    logic              dir_q;
    logic              pass_q;
    logic              mode_q;
    logic [WAIT_W-1:0] dc_q;
    logic              id_match;
    logic              cfg_bad;
    logic              n_bad;
    logic [WAIT_W:0]   dc_diff;
    logic              in_cmd;

    // Configuration screening and dummy-cycle code derivation.
    always_comb begin
        n_bad   = (wait_states > WAIT_W'(DC_BASE)) || wait_states[0];
        cfg_bad = (id_len < ID_LEN_W'(ID_MIN)) || (id_len > ID_LEN_W'(ID_MAX))
                  || (enable_sel && n_bad);
        dc_diff = (WAIT_W+1)'(DC_BASE) - {1'b0, wait_states};
    end

    assign in_cmd    = (state_q != ST_IDLE) && (state_q != ST_FIN);
    assign req_valid = in_cmd && !wait_q;
    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FIN);
    assign ok        = done && pass_q;
    assign err       = done && !pass_q;
    assign octal_mode = mode_q;

    odtr_frame_builder #(
        .WAIT_W   (WAIT_W),
        .ID_LEN_W (ID_LEN_W),
        .LEN_W    (LEN_W)
    ) u_frame (
        .state          (state_q),
        .cur_proto      (mode_q),
        .dc_code        (dc_q),
        .cfg_addr_bytes (cfg_addr_bytes),
        .id_len         (id_len),
        .opcode         (req_opcode),
        .proto          (req_proto),
        .addr           (req_addr),
        .addr_bytes     (req_addr_bytes),
        .dummy          (req_dummy),
        .is_read        (req_is_read),
        .len            (req_len),
        .wdata          (req_wdata)
    );

    odtr_id_check #(
        .ID_MAX   (ID_MAX),
        .ID_LEN_W (ID_LEN_W)
    ) u_idchk (
        .octal    (state_q == ST_RD_OCT),
        .rx_data  (rsp_data),
        .id_bytes (id_bytes),
        .id_len   (id_len),
        .match    (id_match)
    );

    // Sequencer: start screening, frame stepping, response handling, mode update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wait_q  <= 1'b0;
            dir_q   <= 1'b0;
            pass_q  <= 1'b0;
            mode_q  <= 1'b0;
            dc_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    wait_q <= 1'b0;
                    if (start) begin
                        dir_q  <= enable_sel;
                        dc_q   <= WAIT_W'(dc_diff >> 1);
                        pass_q <= 1'b0;
                        if (cfg_bad)
                            state_q <= ST_FIN;
                        else
                            state_q <= enable_sel ? ST_WR_DC : ST_WR_OFF;
                    end
                end
                ST_FIN: state_q <= ST_IDLE;
                default: begin
                    if (req_valid && req_ready) begin
                        wait_q <= 1'b1;
                    end else if (wait_q && rsp_valid) begin
                        wait_q <= 1'b0;
                        if (rsp_err) begin
                            pass_q  <= 1'b0;
                            state_q <= ST_FIN;
                        end else begin
                            case (state_q)
                                ST_WR_DC:  state_q <= ST_WR_ON;
                                ST_WR_ON:  state_q <= ST_RD_OCT;
                                ST_WR_OFF: state_q <= ST_RD_SPI;
                                default: begin
                                    pass_q  <= id_match;
                                    if (id_match)
                                        mode_q <= dir_q;
                                    state_q <= ST_FIN;
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    // R9: done lasts exactly one clock and is reported while still busy.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy && (ok != err));
    // R10: mode keeps its value on failure and follows the direction on success.
    a_r10_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> octal_mode == $past(octal_mode));
    a_r10_set_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> octal_mode == dir_q);
    // R11: an unaccepted request holds its valid and fields.
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_opcode)
            && $stable(req_addr) && $stable(req_wdata) && $stable(req_len));
    // R7: no request is ever presented while idle.
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);
    // R8: an engine error ends the sequence with err on the next clock.
    a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q && rsp_valid && rsp_err |=> err);

endmodule

// File: tb/tb_odtr_switch_seq.sv
`timescale 1ns/1ps
module tb_odtr_switch_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        enable_sel = 1'b0;
    logic [4:0]  wait_states = '0;
    logic [2:0]  cfg_addr_bytes = 3'd4;
    logic [2:0]  id_len = 3'd3;
    logic [47:0] id_bytes = 48'h33_22_11_3A_81_C2;
    logic        req_ready = 1'b0;
    logic        rsp_valid = 1'b0;
    logic        rsp_err = 1'b0;
    logic [95:0] rsp_data = '0;
    logic        busy, done, ok, err, octal_mode, req_valid;
    logic [7:0]  req_opcode;
    logic        req_proto;
    logic [31:0] req_addr;
    logic [2:0]  req_addr_bytes;
    logic [4:0]  req_dummy;
    logic        req_is_read;
    logic [3:0]  req_len;
    logic [15:0] req_wdata;

    int  n_chk = 0;
    int  n_err = 0;
    bit  exp_mode = 1'b0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    odtr_switch_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .enable_sel(enable_sel),
        .wait_states(wait_states), .cfg_addr_bytes(cfg_addr_bytes),
        .id_len(id_len), .id_bytes(id_bytes), .busy(busy), .done(done),
        .ok(ok), .err(err), .octal_mode(octal_mode), .req_valid(req_valid),
        .req_ready(req_ready), .req_opcode(req_opcode), .req_proto(req_proto),
        .req_addr(req_addr), .req_addr_bytes(req_addr_bytes),
        .req_dummy(req_dummy), .req_is_read(req_is_read), .req_len(req_len),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_data(rsp_data)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Per-clock reference comparison of the mode register (R10).
    always @(negedge clk) begin
        if (rst_n && !done && !finished) chk("R10", "mode per clock", octal_mode, exp_mode);
    end

    function automatic logic [95:0] oct_resp(input logic [47:0] id, input int len);
        logic [95:0] r = '0;
        for (int i = 0; i < len; i++) begin
            r[16*i +: 8]   = id[8*i +: 8];
            r[16*i+8 +: 8] = id[8*i +: 8];
        end
        return r;
    endfunction

    function automatic logic [95:0] spi_resp(input logic [47:0] id, input int len);
        logic [95:0] r = '0;
        for (int i = 0; i < len; i++) r[8*i +: 8] = id[8*i +: 8];
        return r;
    endfunction

    task automatic kick(input bit dir, input logic [4:0] n);
        @(negedge clk);
        start = 1'b1; enable_sel = dir; wait_states = n;
        @(negedge clk);
        start = 1'b0;
        chk("R9", "busy after start", busy, 1'b1);
    endtask

    task automatic serve(input string tag, input logic [7:0] op, input bit proto,
                         input logic [31:0] addr, input logic [2:0] ab,
                         input logic [4:0] dm, input bit rd, input logic [3:0] len,
                         input logic [15:0] wd, input int hold, input bit e,
                         input logic [95:0] data);
        int t = 0;
        while (!req_valid && t < 50) begin @(negedge clk); t++; end
        chk(tag, "req_valid", req_valid, 1'b1);
        chk(tag, "opcode", req_opcode, op);
        chk(tag, "proto", req_proto, proto);
        chk(tag, "addr", req_addr, addr);
        chk(tag, "addr_bytes", req_addr_bytes, ab);
        chk(tag, "dummy", req_dummy, dm);
        chk(tag, "is_read", req_is_read, rd);
        chk(tag, "len", req_len, len);
        if (!rd) chk(tag, "wdata", req_wdata, wd);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R11", "valid held", req_valid, 1'b1);
            chk("R11", "opcode held", req_opcode, op);
            chk("R11", "wdata held", req_wdata, wd & {16{!rd}} | req_wdata & {16{rd}});
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk("R11", "valid drops after handshake", req_valid, 1'b0);
        rsp_valid = 1'b1; rsp_err = e; rsp_data = data;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
    endtask

    task automatic finish_expect(input string tag, input bit exp_ok, input bit new_mode);
        int t = 0;
        bit stray = 1'b0;
        while (!done && t < 50) begin
            if (req_valid) stray = 1'b1;
            @(negedge clk); t++;
        end
        chk(tag, "done seen", done, 1'b1);
        chk(tag, "no extra request", stray, 1'b0);
        chk(tag, "ok", ok, exp_ok);
        chk(tag, "err", err, !exp_ok);
        if (exp_ok) exp_mode = new_mode;
        chk("R10", "mode at done", octal_mode, exp_mode);
        @(negedge clk);
        chk("R9", "done one clock", done, 1'b0);
        chk("R9", "busy low after done", busy, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(tag, "quiet after done", req_valid, 1'b0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "req_valid", req_valid, 0);
        chk("R1", "octal_mode", octal_mode, 0);

        // R2 R3 R4: enable, N=8 -> code 6, ID length 3
        kick(1'b1, 5'd8);
        serve("R2", 8'h72, 0, 32'h300, 3'd4, 0, 0, 4'd1, 16'h0006, 0, 0, '0);
        serve("R3", 8'h72, 0, 32'h0, 3'd4, 0, 0, 4'd1, 16'h0002, 0, 0, '0);
        serve("R4", 8'h9F, 1, 32'h0, 3'd4, 5'd4, 1, 4'd6, 0, 0, 0, oct_resp(id_bytes, 3));
        finish_expect("R4", 1'b1, 1'b1);

        // R5 R6 R11: disable with back-pressure
        kick(1'b0, 5'd8);
        serve("R5", 8'h72, 1, 32'h0, 3'd4, 0, 0, 4'd2, 16'h0000, 2, 0, '0);
        serve("R6", 8'h9F, 0, 32'h0, 3'd0, 0, 1, 4'd3, 0, 1, 0, spi_resp(id_bytes, 3));
        finish_expect("R6", 1'b1, 1'b0);

        // R2 R4: N=20 -> code 0, six-byte ID, three address bytes
        id_len = 3'd6; cfg_addr_bytes = 3'd3;
        kick(1'b1, 5'd20);
        serve("R2", 8'h72, 0, 32'h300, 3'd4, 0, 0, 4'd1, 16'h0000, 0, 0, '0);
        serve("R3", 8'h72, 0, 32'h0, 3'd4, 0, 0, 4'd1, 16'h0002, 0, 0, '0);
        serve("R4", 8'h9F, 1, 32'h0, 3'd3, 5'd4, 1, 4'd12, 0, 0, 0, oct_resp(id_bytes, 6));
        finish_expect("R4", 1'b1, 1'b1);

        // R8: engine error on the exit write, mode stays octal
        kick(1'b0, 5'd0);
        serve("R8", 8'h72, 1, 32'h0, 3'd4, 0, 0, 4'd2, 16'h0000, 0, 1, '0);
        finish_expect("R8", 1'b0, 1'b0);

        // R6: wrong ID byte in single mode -> err, mode stays octal
        kick(1'b0, 5'd0);
        serve("R5", 8'h72, 1, 32'h0, 3'd4, 0, 0, 4'd2, 16'h0000, 0, 0, '0);
        serve("R6", 8'h9F, 0, 32'h0, 3'd0, 0, 1, 4'd6, 0, 0, 0,
              spi_resp(id_bytes, 6) ^ 96'h0000_0000_0000_0000_0010_0000);
        finish_expect("R6", 1'b0, 1'b0);

        // R6: good disable back to single mode
        kick(1'b0, 5'd0);
        serve("R5", 8'h72, 1, 32'h0, 3'd4, 0, 0, 4'd2, 16'h0000, 1, 0, '0);
        serve("R6", 8'h9F, 0, 32'h0, 3'd0, 0, 1, 4'd6, 0, 0, 0, spi_resp(id_bytes, 6));
        finish_expect("R6", 1'b1, 1'b0);

        // R4 R10: N=0 -> code 10, second copy of one byte differs -> err
        id_len = 3'd4; cfg_addr_bytes = 3'd4;
        kick(1'b1, 5'd0);
        serve("R2", 8'h72, 0, 32'h300, 3'd4, 0, 0, 4'd1, 16'h000A, 0, 0, '0);
        serve("R3", 8'h72, 0, 32'h0, 3'd4, 0, 0, 4'd1, 16'h0002, 0, 0, '0);
        serve("R4", 8'h9F, 1, 32'h0, 3'd4, 5'd4, 1, 4'd8, 0, 0, 0,
              oct_resp(id_bytes, 4) ^ (96'h1 << 24));
        finish_expect("R4", 1'b0, 1'b1);

        // R7: bad wait-state counts and bad ID length issue no request
        kick(1'b1, 5'd21);
        finish_expect("R7", 1'b0, 1'b1);
        kick(1'b1, 5'd7);
        finish_expect("R7", 1'b0, 1'b1);
        id_len = 3'd2;
        kick(1'b0, 5'd8);
        finish_expect("R7", 1'b0, 1'b0);
        id_len = 3'd3;

        // R9: a start while busy is ignored; N=12 -> code 4
        kick(1'b1, 5'd12);
        start = 1'b1; enable_sel = 1'b0; wait_states = 5'd3;
        @(negedge clk);
        start = 1'b0;
        serve("R9", 8'h72, 0, 32'h300, 3'd4, 0, 0, 4'd1, 16'h0004, 0, 0, '0);
        serve("R3", 8'h72, 0, 32'h0, 3'd4, 0, 0, 4'd1, 16'h0002, 0, 0, '0);
        serve("R4", 8'h9F, 1, 32'h0, 3'd4, 5'd4, 1, 4'd6, 0, 0, 0, oct_resp(id_bytes, 3));
        finish_expect("R9", 1'b1, 1'b1);

        // R2: enable from octal mode sends its writes in octal; N=16 -> code 2
        kick(1'b1, 5'd16);
        serve("R2", 8'h72, 1, 32'h300, 3'd4, 0, 0, 4'd1, 16'h0002, 0, 0, '0);
        serve("R3", 8'h72, 1, 32'h0, 3'd4, 0, 0, 4'd1, 16'h0002, 0, 0, '0);
        serve("R4", 8'h9F, 1, 32'h0, 3'd4, 5'd4, 1, 4'd6, 0, 0, 0, oct_resp(id_bytes, 3));
        finish_expect("R2", 1'b1, 1'b1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule